// File: doc/BRIEF.md
# Block-Ack Window Transmit Tracker

This block keeps transmit status for one aggregation queue. In windowed mode it holds a sliding span of up to 64 consecutive sequence numbers. For every slot in that span it keeps three flags: the frame has been sent, the frame has been acknowledged, and the frame is waiting to be sent again. A frame-sent event marks its slot. A received block-ack carries a start sequence and a 64-bit bitmap. The block compares the bitmap with the slots that have been sent. It reports every newly acknowledged frame as a completion, even when those completions are not in sequence order. It queues the frames that were sent but missed for retransmission. It then moves the window start past the acknowledged frames at the bottom of the window.

In in-order mode only one frame is in flight. That frame is retried until it is acknowledged or until a programmable retry limit is reached. When the limit is reached the frame is dropped. The upstream transmit logic reads the retransmit request and the window start from this block, and the completion and drop pulses go to the status-reporting logic. Windowed mode does not handle fragmented frames.

Top module: `ba_window_tracker`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `win_start` is 0, `retx_valid`, `done_valid`, `drop_valid` and `tx_err` are 0, and `done_mask` is all zero.
- R2: In windowed mode, a frame-sent event is accepted when `(tx_seq - win_start) mod 4096 < 64`. Any other frame-sent event leaves the slot state unchanged and sets `tx_err` high for exactly the cycle after the event.
- R3: In windowed mode, on the cycle after a block-ack, `done_valid` is high and `done_mask` bit `s mod 64` is set for every frame `s` that is sent, not yet acknowledged and acknowledged by that block-ack. Several frames in any sequence order can complete in one pulse, and frames that are already acknowledged or were never sent are never reported. With no block-ack, `done_valid` stays low.
- R4: Bitmap bit i refers to sequence `(ba_ssn + i) mod 4096`. A block-ack changes only the slots that lie both in its 64-sequence range and in the window.
- R5: A frame that is sent, not acknowledged, and covered by a block-ack whose bit for it is 0 becomes pending for retransmission. While any frame is pending, `retx_valid` is 1 and `retx_seq` is the pending frame nearest to `win_start`. Sending that frame again clears its pending flag.
- R6: After each update, `win_start` moves forward past every contiguous acknowledged slot at the bottom of the window, by up to 64 in one step, and those slots are cleared so that they can be reused.
- R7: All sequence arithmetic wraps modulo 4096, so the window and a block-ack range may both straddle sequence 0.
- R8: In in-order mode (`mode_inorder`=1), a frame-sent event while idle makes that frame the single outstanding frame. A block-ack with `ba_ssn` equal to that frame and bitmap bit 0 set raises `done_valid` with `done_mask` bit `seq mod 64` and sets `win_start` to seq+1. A block-ack for any other sequence is ignored.
- R9: In in-order mode, a block-ack for the outstanding frame with bitmap bit 0 clear counts one failed attempt. If the count reaches `retry_limit` (a limit of 0 or 1 drops the frame at its first failure), `drop_valid` pulses with `drop_seq` equal to the frame and `win_start` becomes seq+1. Otherwise `retx_valid`=1 and `retx_seq` is the frame until it is sent again. `done_valid` and `drop_valid` are never high together.
- R10: In in-order mode, a frame-sent event for a different sequence while a frame is outstanding is ignored and sets `tx_err` high for the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_inorder | input | 1 | 0 = windowed block-ack mode, 1 = in-order single-retry mode; change only while idle |
| retry_limit | input | 4 | Failed attempts before an in-order frame is dropped |
| tx_valid | input | 1 | Frame-sent event |
| tx_seq | input | 12 | Sequence number of the sent frame |
| ba_valid | input | 1 | Block-ack received |
| ba_ssn | input | 12 | Start sequence of the block-ack |
| ba_bitmap | input | 64 | Acknowledgment bits; bit i refers to ba_ssn+i |
| win_start | output | 12 | Current window start (next expected sequence in in-order mode) |
| retx_valid | output | 1 | A frame is waiting for retransmission |
| retx_seq | output | 12 | Sequence number to retransmit next |
| done_valid | output | 1 | Completion pulse |
| done_mask | output | 64 | Completed frames, bit = sequence mod 64 |
| drop_valid | output | 1 | In-order frame dropped at the retry limit |
| drop_seq | output | 12 | Sequence number of the dropped frame |
| tx_err | output | 1 | Rejected frame-sent event |

## Verification
The bound checker checks several rules on every cycle:
- An out-of-window send in windowed mode raises the error flag.
- A retransmit request never points outside the window.
- No completion appears without a block-ack.
- Completion and drop pulses never occur together.
- The window start never jumps by more than 64.
- In in-order mode, the window start changes only together with a completion or a drop.

Only the bench's scenarios can show which frames complete, which become pending, the order in which retransmits are offered, and where the window lands after partial block-acks. The same holds for the retry count reaching the limit and for a window that wraps past sequence 0. For those checks the bench compares the outputs with its own model, cycle by cycle.

// File: rtl/ba_track_pkg.sv
package ba_track_pkg;

    localparam int DEF_SEQ_W   = 12;
    localparam int DEF_WIN     = 64;
    localparam int DEF_RETRY_W = 4;

    typedef enum logic {
        MODE_WINDOW  = 1'b0,
        MODE_INORDER = 1'b1
    } trk_mode_e;

    typedef enum logic [1:0] {
        INO_IDLE   = 2'd0,
        INO_WAIT   = 2'd1,
        INO_RESEND = 2'd2
    } ino_state_e;

endpackage

// File: rtl/ba_track_scan.sv
// Rotating find-first: rotates vec so that slot `base` lands at bit 0,
// then reports the lowest set position of the rotated vector.
module ba_track_scan #(
    parameter int N = 64
) (
    input  logic [N-1:0]         vec,
    input  logic [$clog2(N)-1:0] base,
    output logic [$clog2(N)-1:0] first,
    output logic                 hit
);
    localparam int IW = $clog2(N);

    logic [N-1:0] rot;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_rot
            assign rot[gi] = vec[base + IW'(gi)];
        end
    endgenerate

    always_comb begin
        first = '0;
        hit   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (rot[i]) begin
                first = IW'(i);
                hit   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ba_track_win.sv
// Windowed block-ack slot tracker.
module ba_track_win #(
    parameter int SEQ_W = 12,
    parameter int WIN   = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_valid,
    input  logic [SEQ_W-1:0] tx_seq,
    input  logic             ba_valid,
    input  logic [SEQ_W-1:0] ba_ssn,
    input  logic [WIN-1:0]   ba_bitmap,
    output logic             done_valid,
    output logic [WIN-1:0]   done_mask,
    output logic             tx_err,
    output logic             retx_valid,
    output logic [SEQ_W-1:0] retx_seq,
    output logic [SEQ_W-1:0] win_start
);
    localparam int               IW    = $clog2(WIN);
    localparam logic [SEQ_W-1:0] WIN_S = SEQ_W'(WIN);
    localparam logic [IW:0]      WIN_C = (IW+1)'(WIN);

    logic [WIN-1:0]   sent_q, ack_q, pend_q;
    logic [SEQ_W-1:0] ws_q;

    logic [SEQ_W-1:0] tx_off;
    logic             tx_in;
    logic [WIN-1:0]   tx_hit, sent1, newack, nack, ack1, pend1, clr;
    logic [IW:0]      adv;
    logic [IW-1:0]    gap_first, pend_first;
    logic             gap_hit, pend_hit;

    assign tx_off = tx_seq - ws_q;
    assign tx_in  = tx_off < WIN_S;

    genvar k;
    generate
        for (k = 0; k < WIN; k++) begin : g_slot
            logic [IW-1:0]    off_k;
            logic [SEQ_W-1:0] seq_k, bo_k;
            logic             cov_k, bit_k;

            assign off_k  = IW'(k) - ws_q[IW-1:0];
            assign seq_k  = ws_q + SEQ_W'(off_k);
            assign bo_k   = seq_k - ba_ssn;
            assign cov_k  = ba_valid && (bo_k < WIN_S);
            assign bit_k  = ba_bitmap[bo_k[IW-1:0]];

            assign tx_hit[k] = tx_valid && tx_in && (tx_seq[IW-1:0] == IW'(k));
            assign sent1[k]  = sent_q[k] | tx_hit[k];
            assign newack[k] = cov_k & bit_k & sent1[k] & ~ack_q[k];
            assign nack[k]   = cov_k & ~bit_k & sent1[k] & ~ack_q[k];
            assign ack1[k]   = ack_q[k] | newack[k];
            assign pend1[k]  = ((pend_q[k] & ~tx_hit[k]) | nack[k]) & ~ack1[k];
            assign clr[k]    = {1'b0, off_k} < adv;
        end
    endgenerate

    // First unacknowledged slot from the window start sets the advance.
    ba_track_scan #(.N(WIN)) u_gap_scan (
        .vec   (~ack1),
        .base  (ws_q[IW-1:0]),
        .first (gap_first),
        .hit   (gap_hit)
    );

    assign adv = gap_hit ? {1'b0, gap_first} : WIN_C;

    // Nearest pending retransmission from the window start.
    ba_track_scan #(.N(WIN)) u_pend_scan (
        .vec   (pend_q),
        .base  (ws_q[IW-1:0]),
        .first (pend_first),
        .hit   (pend_hit)
    );

    assign retx_valid = pend_hit;
    assign retx_seq   = ws_q + SEQ_W'(pend_first);
    assign win_start  = ws_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sent_q     <= '0;
            ack_q      <= '0;
            pend_q     <= '0;
            ws_q       <= '0;
            done_valid <= 1'b0;
            done_mask  <= '0;
            tx_err     <= 1'b0;
        end else begin
            sent_q     <= sent1 & ~clr;
            ack_q      <= ack1 & ~clr;
            pend_q     <= pend1 & ~clr;
            ws_q       <= ws_q + SEQ_W'(adv);
            done_valid <= |newack;
            done_mask  <= newack;
            tx_err     <= tx_valid & ~tx_in;
        end
    end
endmodule

// File: rtl/ba_track_ino.sv
// In-order single-outstanding controller with retry limit.
module ba_track_ino #(
    parameter int SEQ_W   = 12,
    parameter int WIN     = 64,
    parameter int RETRY_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RETRY_W-1:0] retry_limit,
    input  logic               tx_valid,
    input  logic [SEQ_W-1:0]   tx_seq,
    input  logic               ba_valid,
    input  logic [SEQ_W-1:0]   ba_ssn,
    input  logic               ba_ack0,
    output logic               done_valid,
    output logic [WIN-1:0]     done_mask,
    output logic               drop_valid,
    output logic [SEQ_W-1:0]   drop_seq,
    output logic               tx_err,
    output logic               retx_valid,
    output logic [SEQ_W-1:0]   retx_seq,
    output logic [SEQ_W-1:0]   win_start
);
    import ba_track_pkg::*;

    localparam int IW = $clog2(WIN);

    ino_state_e       st_q;
    logic [SEQ_W-1:0] cur_q, ws_q;
    logic [RETRY_W-1:0] cnt_q;
    logic [RETRY_W:0] cnt_inc;
    logic             resp;

    assign cnt_inc    = {1'b0, cnt_q} + 1'b1;
    assign resp       = ba_valid && (st_q != INO_IDLE) && (ba_ssn == cur_q);
    assign retx_valid = (st_q == INO_RESEND);
    assign retx_seq   = cur_q;
    assign win_start  = ws_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= INO_IDLE;
            cur_q      <= '0;
            ws_q       <= '0;
            cnt_q      <= '0;
            done_valid <= 1'b0;
            done_mask  <= '0;
            drop_valid <= 1'b0;
            drop_seq   <= '0;
            tx_err     <= 1'b0;
        end else begin
            done_valid <= 1'b0;
            done_mask  <= '0;
            drop_valid <= 1'b0;
            tx_err     <= 1'b0;
            if (tx_valid) begin
                if (st_q == INO_IDLE) begin
                    st_q  <= INO_WAIT;
                    cur_q <= tx_seq;
                    cnt_q <= '0;
                end else if (tx_seq != cur_q) begin
                    tx_err <= 1'b1;
                end else begin
                    st_q <= INO_WAIT;
                end
            end
            if (resp) begin
                if (ba_ack0) begin
                    done_valid <= 1'b1;
                    done_mask  <= WIN'(1) << cur_q[IW-1:0];
                    st_q       <= INO_IDLE;
                    ws_q       <= cur_q + 1'b1;
                end else if (cnt_inc >= {1'b0, retry_limit}) begin
                    drop_valid <= 1'b1;
                    drop_seq   <= cur_q;
                    st_q       <= INO_IDLE;
                    ws_q       <= cur_q + 1'b1;
                end else begin
                    cnt_q <= cnt_inc[RETRY_W-1:0];
                    st_q  <= INO_RESEND;
                end
            end
        end
    end
endmodule

// File: rtl/ba_window_tracker.sv
module ba_window_tracker #(
    parameter int SEQ_W   = ba_track_pkg::DEF_SEQ_W,
    parameter int WIN     = ba_track_pkg::DEF_WIN,
    parameter int RETRY_W = ba_track_pkg::DEF_RETRY_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_inorder,
    input  logic [RETRY_W-1:0] retry_limit,
    input  logic               tx_valid,
    input  logic [SEQ_W-1:0]   tx_seq,
    input  logic               ba_valid,
    input  logic [SEQ_W-1:0]   ba_ssn,
    input  logic [WIN-1:0]     ba_bitmap,
    output logic [SEQ_W-1:0]   win_start,
    output logic               retx_valid,
    output logic [SEQ_W-1:0]   retx_seq,
    output logic               done_valid,
    output logic [WIN-1:0]     done_mask,
    output logic               drop_valid,
    output logic [SEQ_W-1:0]   drop_seq,
    output logic               tx_err
);
    import ba_track_pkg::*;

    trk_mode_e mode;
    assign mode = trk_mode_e'(mode_inorder);

    logic             w_sel, i_sel;
    logic             w_done, w_err, w_retx;
    logic [WIN-1:0]   w_mask;
    logic [SEQ_W-1:0] w_rseq, w_ws;
    logic             i_done, i_drop, i_err, i_retx;
    logic [WIN-1:0]   i_mask;
    logic [SEQ_W-1:0] i_dseq, i_rseq, i_ws;

    assign w_sel = (mode == MODE_WINDOW);
    assign i_sel = (mode == MODE_INORDER);

    ba_track_win #(.SEQ_W(SEQ_W), .WIN(WIN)) u_win (
        .clk        (clk),
        .rst        (rst),
        .tx_valid   (tx_valid & w_sel),
        .tx_seq     (tx_seq),
        .ba_valid   (ba_valid & w_sel),
        .ba_ssn     (ba_ssn),
        .ba_bitmap  (ba_bitmap),
        .done_valid (w_done),
        .done_mask  (w_mask),
        .tx_err     (w_err),
        .retx_valid (w_retx),
        .retx_seq   (w_rseq),
        .win_start  (w_ws)
    );

    ba_track_ino #(.SEQ_W(SEQ_W), .WIN(WIN), .RETRY_W(RETRY_W)) u_ino (
        .clk         (clk),
        .rst         (rst),
        .retry_limit (retry_limit),
        .tx_valid    (tx_valid & i_sel),
        .tx_seq      (tx_seq),
        .ba_valid    (ba_valid & i_sel),
        .ba_ssn      (ba_ssn),
        .ba_ack0     (ba_bitmap[0]),
        .done_valid  (i_done),
        .done_mask   (i_mask),
        .drop_valid  (i_drop),
        .drop_seq    (i_dseq),
        .tx_err      (i_err),
        .retx_valid  (i_retx),
        .retx_seq    (i_rseq),
        .win_start   (i_ws)
    );

    assign win_start  = i_sel ? i_ws   : w_ws;
    assign retx_valid = i_sel ? i_retx : w_retx;
    assign retx_seq   = i_sel ? i_rseq : w_rseq;
    assign done_valid = i_sel ? i_done : w_done;
    assign done_mask  = i_sel ? i_mask : w_mask;
    assign drop_valid = i_sel & i_drop;
    assign drop_seq   = i_dseq;
    assign tx_err     = i_sel ? i_err  : w_err;
endmodule

// File: rtl/ba_window_tracker_chk.sv
module ba_window_tracker_chk #(
    parameter int SEQ_W   = 12,
    parameter int WIN     = 64,
    parameter int RETRY_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               mode_inorder,
    input logic [RETRY_W-1:0] retry_limit,
    input logic               tx_valid,
    input logic [SEQ_W-1:0]   tx_seq,
    input logic               ba_valid,
    input logic [SEQ_W-1:0]   ba_ssn,
    input logic [WIN-1:0]     ba_bitmap,
    input logic [SEQ_W-1:0]   win_start,
    input logic               retx_valid,
    input logic [SEQ_W-1:0]   retx_seq,
    input logic               done_valid,
    input logic [WIN-1:0]     done_mask,
    input logic               drop_valid,
    input logic [SEQ_W-1:0]   drop_seq,
    input logic               tx_err
);
    localparam logic [SEQ_W-1:0] WIN_S = SEQ_W'(WIN);

    // R2
    out_of_window_err_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_inorder && tx_valid && ((tx_seq - win_start) >= WIN_S)) |=> tx_err);

    // R5
    retx_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_inorder && retx_valid) |-> ((retx_seq - win_start) < WIN_S));

    // R3
    done_needs_ba_chk: assert property (@(posedge clk) disable iff (rst)
        !ba_valid |=> !done_valid);

    // R9
    done_drop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_valid, drop_valid}));

    // R6
    ws_step_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_inorder && $past(!mode_inorder)) |-> ((win_start - $past(win_start)) <= WIN_S));

    // R8
    ino_ws_moves_on_end_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_inorder && $past(mode_inorder) && !done_valid && !drop_valid) |-> $stable(win_start));
endmodule

bind ba_window_tracker ba_window_tracker_chk #(
    .SEQ_W(SEQ_W), .WIN(WIN), .RETRY_W(RETRY_W)
) u_chk (
    .clk(clk), .rst(rst), .mode_inorder(mode_inorder), .retry_limit(retry_limit),
    .tx_valid(tx_valid), .tx_seq(tx_seq), .ba_valid(ba_valid), .ba_ssn(ba_ssn),
    .ba_bitmap(ba_bitmap), .win_start(win_start), .retx_valid(retx_valid),
    .retx_seq(retx_seq), .done_valid(done_valid), .done_mask(done_mask),
    .drop_valid(drop_valid), .drop_seq(drop_seq), .tx_err(tx_err)
);

// File: tb/ba_window_tracker_tb.sv
`timescale 1ns/1ps
module ba_window_tracker_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        mode_inorder;
    logic [3:0]  retry_limit;
    logic        tx_valid;
    logic [11:0] tx_seq;
    logic        ba_valid;
    logic [11:0] ba_ssn;
    logic [63:0] ba_bitmap;
    logic [11:0] win_start, retx_seq, drop_seq;
    logic        retx_valid, done_valid, drop_valid, tx_err;
    logic [63:0] done_mask;

    always #4 clk = ~clk;

    ba_window_tracker u_dut (
        .clk(clk), .rst(rst), .mode_inorder(mode_inorder), .retry_limit(retry_limit),
        .tx_valid(tx_valid), .tx_seq(tx_seq), .ba_valid(ba_valid), .ba_ssn(ba_ssn),
        .ba_bitmap(ba_bitmap), .win_start(win_start), .retx_valid(retx_valid),
        .retx_seq(retx_seq), .done_valid(done_valid), .done_mask(done_mask),
        .drop_valid(drop_valid), .drop_seq(drop_seq), .tx_err(tx_err)
    );

    typedef struct {
        bit          dv;
        logic [63:0] dm;
        bit          drv;
        logic [11:0] drs;
        bit          er;
        bit          rv;
        logic [11:0] rs;
        logic [11:0] ws;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   over   = 1'b0;

    // reference state
    bit          m_sent [0:4095];
    bit          m_ack  [0:4095];
    bit          m_pend [0:4095];
    logic [11:0] m_ws;
    bit          c_mode;
    logic [3:0]  c_lim;
    bit          i_busy, i_need;
    logic [11:0] i_cur, i_ws;
    int          i_cnt;

    task automatic step(input bit txv, input logic [11:0] txs, input bit bav,
                        input logic [11:0] ssn, input logic [63:0] bm, input string tag);
        exp_t e;
        logic [11:0] d, s;
        @(negedge clk);
        mode_inorder = c_mode;
        retry_limit  = c_lim;
        tx_valid = txv; tx_seq = txs; ba_valid = bav; ba_ssn = ssn; ba_bitmap = bm;
        e.dv = 0; e.dm = '0; e.drv = 0; e.drs = '0; e.er = 0; e.rv = 0; e.rs = '0; e.tag = tag;
        if (!c_mode) begin
            d = txs - m_ws;
            if (txv && d >= 12'd64) e.er = 1;
            if (txv && d < 12'd64) begin m_sent[txs] = 1; m_pend[txs] = 0; end
            if (bav) begin
                for (int i = 0; i < 64; i++) begin
                    s = ssn + 12'(i);
                    d = s - m_ws;
                    if (d < 12'd64 && m_sent[s] && !m_ack[s]) begin
                        if (bm[i]) begin m_ack[s] = 1; e.dm[s[5:0]] = 1'b1; end
                        else m_pend[s] = 1;
                    end
                end
            end
            e.dv = (e.dm != 0);
            for (int n = 0; n < 64; n++) begin
                if (!m_ack[m_ws]) break;
                m_ack[m_ws] = 0; m_sent[m_ws] = 0; m_pend[m_ws] = 0;
                m_ws = m_ws + 12'd1;
            end
            for (int off = 0; off < 64; off++) begin
                s = m_ws + 12'(off);
                if (!e.rv && m_pend[s]) begin e.rv = 1; e.rs = s; end
            end
            e.ws = m_ws;
        end else begin
            if (txv) begin
                if (!i_busy) begin i_busy = 1; i_cur = txs; i_cnt = 0; i_need = 0; end
                else if (txs != i_cur) e.er = 1;
                else i_need = 0;
            end
            if (bav && i_busy && ssn == i_cur) begin
                if (bm[0]) begin
                    e.dv = 1; e.dm = 64'd1 << i_cur[5:0];
                    i_busy = 0; i_need = 0; i_ws = i_cur + 12'd1;
                end else if (i_cnt + 1 >= int'(c_lim)) begin
                    e.drv = 1; e.drs = i_cur;
                    i_busy = 0; i_need = 0; i_ws = i_cur + 12'd1;
                end else begin
                    i_cnt = i_cnt + 1; i_need = 1;
                end
            end
            e.rv = i_need; e.rs = i_cur; e.ws = i_ws;
        end
        q.push_back(e);
    endtask

    task automatic send(input logic [11:0] s, input string tag);
        step(1, s, 0, 12'd0, 64'd0, tag);
    endtask
    task automatic back(input logic [11:0] ssn, input logic [63:0] bm, input string tag);
        step(0, 12'd0, 1, ssn, bm, tag);
    endtask
    task automatic idle(input string tag);
        step(0, 12'd0, 0, 12'd0, 64'd0, tag);
    endtask

    task automatic summary;
        if (!over) begin
            over = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        end
    endtask

    // monitor: pops one expected record per cycle, away from the clock edge
    initial begin
        exp_t e;
        bit bad;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                bad = 0;
                n_chk++;
                if (done_valid !== e.dv || done_mask !== e.dm) begin
                    $display("FAIL %s done act=%0b/%h exp=%0b/%h", e.tag, done_valid, done_mask, e.dv, e.dm); bad = 1;
                end
                if (drop_valid !== e.drv || (e.drv && drop_seq !== e.drs)) begin
                    $display("FAIL %s drop act=%0b/%0d exp=%0b/%0d", e.tag, drop_valid, drop_seq, e.drv, e.drs); bad = 1;
                end
                if (tx_err !== e.er) begin
                    $display("FAIL %s tx_err act=%0b exp=%0b", e.tag, tx_err, e.er); bad = 1;
                end
                if (retx_valid !== e.rv || (e.rv && retx_seq !== e.rs)) begin
                    $display("FAIL %s retx act=%0b/%0d exp=%0b/%0d", e.tag, retx_valid, retx_seq, e.rv, e.rs); bad = 1;
                end
                if (win_start !== e.ws) begin
                    $display("FAIL %s win_start act=%0d exp=%0d", e.tag, win_start, e.ws); bad = 1;
                end
                if (bad) n_fail++;
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!over) begin
            n_fail++;
            $display("FAIL watchdog act=timeout exp=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [11:0] b;
        rst = 1; mode_inorder = 0; retry_limit = 4'd3;
        tx_valid = 0; tx_seq = '0; ba_valid = 0; ba_ssn = '0; ba_bitmap = '0;
        for (int i = 0; i < 4096; i++) begin m_sent[i] = 0; m_ack[i] = 0; m_pend[i] = 0; end
        m_ws = '0; c_mode = 0; c_lim = 4'd3;
        i_busy = 0; i_need = 0; i_cur = '0; i_ws = '0; i_cnt = 0;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        n_chk++;
        if (win_start !== 12'd0 || retx_valid !== 1'b0 || done_valid !== 1'b0 ||
            drop_valid !== 1'b0 || tx_err !== 1'b0 || done_mask !== 64'd0) begin
            n_fail++;
            $display("FAIL R1 reset act=ws%0d r%0b d%0b p%0b e%0b exp=ws0 r0 d0 p0 e0",
                     win_start, retx_valid, done_valid, drop_valid, tx_err);
        end
        rst = 0;
        idle("R1");

        // R2: in-window sends, then an out-of-window send
        for (int s = 0; s < 10; s++) send(12'(s), "R2");
        send(12'd100, "R2");
        idle("R2");
        // R3 / R5: out-of-order completions, the rest become pending
        back(12'd0, 64'h0000_0000_0000_00A4, "R3");
        idle("R5");
        send(12'd0, "R5");
        send(12'd1, "R5");
        // R6: acknowledging 0,1,3 closes the gap up to 4
        back(12'd0, 64'h0000_0000_0000_000B, "R6");
        // R4: offset mapping, bit 2 of ssn 2 is seq 4
        back(12'd2, 64'h0000_0000_0000_0004, "R4");
        // R4: a block-ack for frames that were never sent
        back(12'd20, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
        // R5: resend 6 and 8, ack them, the leftover pending frame is 9
        send(12'd6, "R5");
        send(12'd8, "R5");
        back(12'd6, 64'h0000_0000_0000_0005, "R5");
        send(12'd9, "R5");
        back(12'd9, 64'h0000_0000_0000_0001, "R6");
        idle("R6");

        // R6 / R7: full windows acknowledged at once, walking towards the wrap
        while (m_ws < 12'd4000) begin
            b = m_ws;
            for (int i = 0; i < 64; i++) send(b + 12'(i), "R6");
            if (b < 12'd100) begin
                send(b + 12'd64, "R2");
                send(b - 12'd1, "R2");
            end
            back(b, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
        end
        // Bring the window start close to 4095.
        while (m_ws < 12'd4090) begin
            b = m_ws;
            send(b, "R7");
            back(b, 64'h1, "R7");
        end
        // R7: frames straddling sequence 0
        b = m_ws;
        for (int i = 0; i < 20; i++) send(b + 12'(i), "R7");
        back(b + 12'd10, 64'h0000_0000_0000_03FF, "R7");
        back(b, 64'h0000_0000_0000_03FF, "R7");
        idle("R7");

        // R8: in-order mode, acknowledged at once
        c_mode = 1; c_lim = 4'd3;
        idle("R8");
        send(12'd300, "R8");
        back(12'd299, 64'h1, "R8");
        back(12'd300, 64'h1, "R8");
        // R9: three failures with limit 3
        send(12'd301, "R9");
        back(12'd301, 64'h0, "R9");
        send(12'd301, "R9");
        back(12'd301, 64'h0, "R9");
        send(12'd301, "R9");
        back(12'd301, 64'h0, "R9");
        idle("R9");
        // R10: a different sequence while busy is rejected
        send(12'd302, "R10");
        send(12'd303, "R10");
        back(12'd302, 64'h1, "R10");
        back(12'd303, 64'h1, "R10");
        // R9: limit 0 drops on the first failure
        c_lim = 4'd0;
        send(12'd310, "R9");
        back(12'd310, 64'h0, "R9");
        idle("R9");

        // R2: back to windowed mode, the saved window still holds
        c_mode = 0;
        idle("R2");
        send(m_ws + 12'd70, "R2");
        idle("R2");

        while (q.size() > 0) @(posedge clk);
        @(negedge clk);
        summary();
        $finish;
    end
endmodule